// File: doc/BRIEF.md
# Two-Wire Bus Byte-Memory Slave

This block is a two-wire serial bus slave that sits in front of a 1024-byte on-chip memory. It runs on a system clock much faster than the bus clock. Both bus lines are resynchronized, and the block decodes START and STOP conditions from the synchronized copies. It then checks an 8-bit address byte against a fixed type code and the level of one strap pin. A matching write header is followed by one word-address byte and then any number of data bytes. A read header streams bytes out of memory for as long as the master acknowledges each one.

The address byte carries two page bits. These supply the upper two bits of the 10-bit memory address, and the word-address byte supplies the lower eight. One internal pointer advances after every byte stored or sent. A read with no word-address phase before it therefore continues from where the last access ended. The block never drives the data line high: it has one output enable that pulls the line low, and that enable only changes while the clock line is low.

Top module: `i2cmem_slave`

## Requirements
- R1: The block ignores clocked bits until it has seen a START (data line falling while the clock line is high). A valid address byte clocked in with no START before it gets no acknowledge.
- R2: A STOP (data line rising while the clock line is high) returns the block to standby and releases the data line. An address byte clocked in after a STOP, with no new START, gets no acknowledge.
- R3: An address byte whose bits 7:4 are 1010 and whose bit 3 equals `sel_strap` is acknowledged. The block pulls the data line low during the ninth clock.
- R4: An address byte with a different type code, or with bit 3 not equal to `sel_strap`, gets no acknowledge. The block then ignores every byte until the next START, and memory is left unchanged.
- R5: Bits 2:1 of the address byte form memory address bits 9:8. The word-address byte that follows a write header (bit 0 = 0) forms bits 7:0.
- R6: Each data byte after the word address is acknowledged and stored at the pointer, and the pointer then advances by one.
- R7: A write header and word address, followed by a repeated START and a read header (bit 0 = 1), returns the byte stored at that address, MSB first.
- R8: During a read, a low acknowledge from the master makes the block send the byte at the next address. A high (missing) acknowledge makes it release the data line and stay silent until STOP or START.
- R9: A read header with no word-address phase before it reads from the current pointer, with the header's page bits replacing pointer bits 9:8.
- R10: The pointer wraps from 0x3FF to 0x000 for both writes and reads.
- R11: The data line is only ever pulled low, and the output enable changes only while the clock line is low.
- R12: After reset the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sel_strap | input | 1 | Device-select strap, compared with bit 3 of the address byte |
| sda_oe | output | 1 | When high, the data line is pulled low |

## Verification
A wrong pointer or page register appears at the ports on the first read that follows it. The wrong byte comes out within eight bus clocks of the read header's acknowledge, and the bench compares every read byte against its own memory model. A wrong phase register shows up as a missing or spurious acknowledge in the ninth clock of the byte concerned, or as driven bits after a master's missing acknowledge. A late or early change of the enable is caught against the clock-line level in the same system cycle.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADR,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_RACK,
      ST_SKIP
   } bus_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int LINES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cmem_sync: STAGES must be at least 2");
   end

   logic [LINES-1:0] raw;
   logic [LINES-1:0] synced;
   logic [LINES-1:0] prev;

   assign raw = {scl_i, sda_i};

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain   <= '1;
            prev[l] <= 1'b1;
         end else begin
            chain   <= {chain[STAGES-2:0], raw[l]};
            prev[l] <= chain[STAGES-1];
         end
      end
      assign synced[l] = chain[STAGES-1];
   end

   assign scl_s     = synced[1];
   assign sda_s     = synced[0];
   assign scl_rise  = synced[1] & ~prev[1];
   assign scl_fall  = ~synced[1] & prev[1];
   assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
   assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/i2cmem_ram.sv
module i2cmem_ram #(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 8,
   parameter bit SYNC_READ = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W > 12) begin : g_bad_depth
      $error("i2cmem_ram: ADDR_W too large for an on-chip array");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   if (SYNC_READ) begin : g_reg_read
      always_ff @(posedge clk) rdata <= mem[raddr];
   end else begin : g_comb_read
      assign rdata = mem[raddr];
   end
endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
   import i2cmem_pkg::*;
#(
   parameter int          PAGE_W    = 2,
   parameter logic [7:0]  TYPE_CODE = 8'h0A
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sda_s,
   input  logic                       scl_rise,
   input  logic                       scl_fall,
   input  logic                       start_det,
   input  logic                       stop_det,
   input  logic                       sel_strap,
   input  logic [BYTE_W-1:0]          mem_rdata,
   output logic                       mem_we,
   output logic [PAGE_W+BYTE_W-1:0]   mem_waddr,
   output logic [BYTE_W-1:0]          mem_wdata,
   output logic [PAGE_W+BYTE_W-1:0]   mem_raddr,
   output logic                       sda_oe,
   output bus_state_e                 state_o
);
   localparam int ADDR_W  = PAGE_W + BYTE_W;
   localparam int TYPE_W  = BYTE_W - PAGE_W - 2;
   localparam int SEL_BIT = PAGE_W + 1;
   localparam int CNT_W   = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

   if (PAGE_W < 1 || PAGE_W > 3) begin : g_bad_page
      $error("i2cmem_ctrl: PAGE_W must be 1..3");
   end

   bus_state_e          state, after;
   logic [CNT_W-1:0]    cnt;
   logic [BYTE_W-1:0]   rx_sh, tx_sh;
   logic [ADDR_W-1:0]   ptr;
   logic [PAGE_W-1:0]   page;
   logic                master_ack;
   logic                hdr_match;

   assign hdr_match = (rx_sh[BYTE_W-1 -: TYPE_W] == TYPE_CODE[TYPE_W-1:0])
                    && (rx_sh[SEL_BIT] == sel_strap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         after      <= ST_IDLE;
         cnt        <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         ptr        <= '0;
         page       <= '0;
         master_ack <= 1'b0;
         sda_oe     <= 1'b0;
         mem_we     <= 1'b0;
         mem_waddr  <= '0;
         mem_wdata  <= '0;
      end else begin
         mem_we <= 1'b0;
         if (start_det) begin
            state  <= ST_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_WADR, ST_WDAT: begin
                  if (scl_rise) begin
                     rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     cnt <= '0;
                     if (state == ST_DEV) begin
                        if (hdr_match) begin
                           sda_oe <= 1'b1;
                           state  <= ST_ACK;
                           page   <= rx_sh[PAGE_W:1];
                           if (rx_sh[0]) begin
                              after <= ST_RDAT;
                              ptr   <= {rx_sh[PAGE_W:1], ptr[BYTE_W-1:0]};
                           end else begin
                              after <= ST_WADR;
                           end
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else if (state == ST_WADR) begin
                        ptr    <= {page, rx_sh};
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                        after  <= ST_WDAT;
                     end else begin
                        mem_we    <= 1'b1;
                        mem_waddr <= ptr;
                        mem_wdata <= rx_sh;
                        ptr       <= ptr + 1'b1;
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after     <= ST_WDAT;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     state <= after;
                     cnt   <= '0;
                     if (after == ST_RDAT) begin
                        tx_sh  <= mem_rdata;
                        sda_oe <= ~mem_rdata[BYTE_W-1];
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                        ptr    <= ptr + 1'b1;
                        cnt    <= '0;
                     end else begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_W-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     master_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (master_ack) begin
                        tx_sh  <= mem_rdata;
                        sda_oe <= ~mem_rdata[BYTE_W-1];
                        state  <= ST_RDAT;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign mem_raddr = ptr;
   assign state_o   = state;
endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
   import i2cmem_pkg::*;
#(
   parameter int         PAGE_W      = 2,
   parameter logic [7:0] TYPE_CODE   = 8'h0A,
   parameter int         SYNC_STAGES = 2,
   parameter bit         SYNC_READ   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic sel_strap,
   output logic sda_oe
);
   localparam int ADDR_W = PAGE_W + BYTE_W;

   logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr, mem_raddr;
   logic [BYTE_W-1:0] mem_wdata, mem_rdata;
   bus_state_e        state_w;

   i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cmem_ctrl #(.PAGE_W(PAGE_W), .TYPE_CODE(TYPE_CODE)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sel_strap (sel_strap),
      .mem_rdata (mem_rdata),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata),
      .mem_raddr (mem_raddr),
      .sda_oe    (sda_oe),
      .state_o   (state_w)
   );

   i2cmem_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .SYNC_READ(SYNC_READ)) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );
endmodule

// File: rtl/i2cmem_chk.sv
module i2cmem_chk
   import i2cmem_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       start_det,
   input logic       stop_det,
   input logic       sda_oe,
   input bus_state_e state
);
   a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_oe && state == ST_DEV));

   a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && state == ST_IDLE));

   a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_SKIP |-> !sda_oe);

   a_r8_master_ack_window_free: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_RACK |-> !sda_oe);

   a_r3_rx_bits_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV || state == ST_WADR || state == ST_WDAT || state == ST_IDLE) |-> !sda_oe);
endmodule

bind i2cmem_slave i2cmem_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe),
   .state     (state_w)
);

// File: tb/i2cmem_slave_tb.sv
module i2cmem_slave_tb;
   localparam int Q     = 5;
   localparam int DEPTH = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic strap = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [7:0] model [DEPTH];
   int checks = 0;
   int fails = 0;
   int oe_bad = 0;
   bit timed_out = 1'b0;
   bit oe_prev = 1'b0;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2cmem_slave u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .sel_strap (strap),
      .sda_oe    (sda_oe)
   );

   // R11 monitor: enable may only change while the clock line is low
   always @(negedge clk) begin
      if (rst_n && sda_oe !== oe_prev && scl) oe_bad++;
      oe_prev = sda_oe;
   end

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + (a >> 8) * 91 + 11) & 8'hFF);
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      sda_m = 1'b0; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bit(bit b);
      sda_m = b;  tick(Q);
      scl = 1'b1; tick(2 * Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output bit b);
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      b = sda_line; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic send_byte(logic [7:0] d, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input bit give_ack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~give_ack);
   endtask

   function automatic logic [7:0] hdr(bit sel, int a, bit rd);
      return {4'b1010, sel, 2'((a >> 8) & 3), rd};
   endfunction

   task automatic write_bytes(int a, int n);
      bit ack;
      bus_start();
      send_byte(hdr(strap, a, 1'b0), ack); chk("R3 write header ack", ack, 1);
      send_byte(8'(a & 8'hFF), ack);       chk("R5 word address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         int ad = (a + k) % DEPTH;
         send_byte(pat(ad), ack);          chk("R6 data ack", ack, 1);
         model[ad] = pat(ad);
      end
      bus_stop();
   endtask

   task automatic read_random(int a, int n, string req);
      bit ack;
      logic [7:0] d;
      bus_start();
      send_byte(hdr(strap, a, 1'b0), ack); chk("R3 header ack", ack, 1);
      send_byte(8'(a & 8'hFF), ack);       chk("R5 word address ack", ack, 1);
      bus_start();
      send_byte(hdr(strap, a, 1'b1), ack); chk("R7 read header ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(d, k < n - 1);
         chk(req, d, model[(a + k) % DEPTH]);
      end
      bus_stop();
   endtask

   task automatic run_all();
      bit ack;
      logic [7:0] d;
      tick(4);
      chk("R12 reset enable", sda_oe, 0);
      rst_n = 1'b1;
      tick(4);
      chk("R12 idle enable", sda_oe, 0);

      // R1: header without a START
      send_byte(hdr(1'b1, 0, 1'b0), ack);
      chk("R1 no ack without START", ack, 0);
      bus_stop();

      // R5 R6 R7 R8: sweep of pages and offsets
      for (int p = 0; p < 4; p++) begin
         for (int o = 0; o < 3; o++) begin
            int off = (o == 0) ? 8'h00 : (o == 1) ? 8'h7F : 8'hF8;
            write_bytes(p * 256 + off, 4);
         end
      end
      for (int p = 0; p < 4; p++) begin
         for (int o = 0; o < 3; o++) begin
            int off = (o == 0) ? 8'h00 : (o == 1) ? 8'h7F : 8'hF8;
            read_random(p * 256 + off, 4, "R7 R8 sequential read data");
         end
      end

      // R10: wrap at the top of the address space
      write_bytes(10'h3FE, 3);
      read_random(10'h3FF, 2, "R10 wrap read data");

      // R9: current-address read, page bits replace pointer bits 9:8 (pointer now 0x001)
      bus_start();
      send_byte(hdr(strap, 10'h200, 1'b1), ack); chk("R9 header ack", ack, 1);
      recv_byte(d, 1'b0);
      chk("R9 current address data", d, model[10'h201]);
      bus_stop();

      // R8: after a missing acknowledge the block stays silent
      bus_start();
      send_byte(hdr(strap, 10'h100, 1'b1), ack); chk("R8 header ack", ack, 1);
      recv_byte(d, 1'b0);
      chk("R8 first byte", d, model[10'h102]);
      recv_byte(d, 1'b1);
      chk("R8 silent after nack", d, 8'hFF);
      bus_stop();

      // R4: wrong select bit, then wrong type code
      bus_start();
      send_byte(hdr(~strap, 10'h010, 1'b0), ack); chk("R4 wrong select no ack", ack, 0);
      send_byte(8'h01, ack);                      chk("R4 ignored word address", ack, 0);
      send_byte(8'h5A, ack);                      chk("R4 ignored data", ack, 0);
      bus_stop();
      bus_start();
      send_byte({4'b1011, strap, 2'b00, 1'b0}, ack); chk("R4 wrong type no ack", ack, 0);
      send_byte(8'h01, ack);                      chk("R4 ignored word address 2", ack, 0);
      send_byte(8'hA5, ack);                      chk("R4 ignored data 2", ack, 0);
      bus_stop();
      read_random(10'h001, 1, "R4 memory unchanged");

      // R3 with the strap low
      strap = 1'b0;
      tick(4);
      write_bytes(10'h020, 1);
      read_random(10'h020, 1, "R3 strap low read back");
      bus_start();
      send_byte(hdr(1'b1, 0, 1'b1), ack); chk("R3 strap low rejects select 1", ack, 0);
      bus_stop();
      strap = 1'b1;
      tick(4);

      // R2: no START after STOP
      send_byte(hdr(strap, 0, 1'b0), ack);
      chk("R2 no ack after STOP", ack, 0);
      bus_stop();

      chk("R11 enable changed with clock line high", oe_bad, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            tick(180000);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule